// File: doc/BRIEF.md
# Next Sub-bank Predictive Precharge Controller

This block decides which sub-bank of a sub-banked instruction cache has its bitlines precharged. Exactly one sub-bank is precharged at a time, and the others have precharge gated off to cut bitline leakage. The default sizing is for a 32 KB, 2-way set-associative cache with 512 sets per way and four sub-banks. Each fetch presents a set index and a sub-bank index together with a valid flag.

If a fetch lands in a sub-bank that is not precharged, the block holds the requester with a stall output for a programmable wake-up delay. It then moves precharge to that sub-bank and accepts the fetch once the stall drops. Most changes of sub-bank come from sequential fetch running over a boundary or from unconditional jumps, and these repeat. The block therefore trains a small direct-mapped table that records which sub-bank followed a given fetch. When the table predicts a different sub-bank for an accepted fetch, precharge moves there early and the wake-up delay is hidden.

Top module: `sbPrechargeCtl`

## Requirements
- R1: The output `prechargeEn` is one-hot at all times, including during a stall. Bit k high means that sub-bank k is precharged.
- R2: After reset, `prechargeEn` equals 1 (sub-bank 0), `stall` is low, and no table entry gives a prediction.
- R3: A valid fetch whose sub-bank is already precharged is accepted in the same cycle, with `stall` low.
- R4: A valid fetch to a sub-bank that is not precharged raises `stall` for exactly WAKE_CYCLES consecutive cycles. `prechargeEn` selects that sub-bank from the cycle after the fetch first appears. The fetch is accepted in the first cycle with `stall` low, and the requester holds the fetch inputs while `stall` is high.
- R5: The table index is formed by zero-extending or truncating the set index to the table's address width (log2 TABLE_DEPTH bits) and XORing it with the zero-extended sub-bank index. Different sets that map to the same index therefore share one entry.
- R6: When an accepted fetch's sub-bank differs from the sub-bank of the previously accepted fetch, the entry at the previous fetch's index is written as valid with the new sub-bank. While no fetch has been accepted since reset, nothing is written.
- R7: When an accepted fetch reads a valid entry whose predicted sub-bank differs from its own, `prechargeEn` selects the predicted sub-bank in the following cycle.
- R8: When an accepted fetch reads a valid entry that predicts its own sub-bank, precharge stays on that sub-bank.
- R9: When a training write and a lookup address the same entry in one cycle, the lookup uses the entry's contents from before that write.
- R10: In cycles with `fetchValid` low and no wake-up in progress, `prechargeEn` keeps its value and `stall` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A fetch is presented this cycle |
| fetchSet | input | SET_BITS | Set index of the fetch |
| fetchSubBank | input | $clog2(NUM_SUBBANKS) | Sub-bank index of the fetch |
| prechargeEn | output | NUM_SUBBANKS | One-hot precharge enable per sub-bank |
| stall | output | 1 | Hold the fetch: its sub-bank is waking up |

## Verification
Two functions can fall in the same cycle: training the entry of the previous fetch and the predictive lookup for the current fetch. They collide when both fetches map to the same table index. The bench first trains an entry so that it predicts sub-bank 3. It then follows a fetch at set 20 in sub-bank 0 with a fetch at set 21 in sub-bank 1; both map to index 20, so the second fetch writes sub-bank 1 into the same entry it reads. The check passes when precharge moves to sub-bank 3, the value from before the write. A bench-side reference model of the table, stall length and precharge position scores every accepted fetch.

// File: rtl/sbPrechargePkg.sv
package sbPrechargePkg;

  // strobes from the control to the datapath, one cycle's worth
  typedef struct packed {
    logic accept;      // fetch is taken this cycle
    logic wakeSwitch;  // move precharge to the fetch's sub-bank
    logic train;       // write the previous fetch's entry
    logic predict;     // move precharge to the predicted sub-bank
  } pcStrobe_t;

  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_WAKE = 1'b1
  } ctlState_t;

endpackage

// File: rtl/sbPrechargeDp.sv
module sbPrechargeDp
  import sbPrechargePkg::*;
#(
  parameter int NUM_SUBBANKS = 4,
  parameter int SET_BITS     = 9,
  parameter int TABLE_DEPTH  = 64
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [SET_BITS-1:0]             fetchSet,
  input  logic [$clog2(NUM_SUBBANKS)-1:0] fetchSubBank,
  input  pcStrobe_t                       strobes,
  output logic                            bankMiss,
  output logic                            crossing,
  output logic                            predHit,
  output logic [NUM_SUBBANKS-1:0]         prechargeEn
);

  localparam int SB_W  = $clog2(NUM_SUBBANKS);
  localparam int IDX_W = $clog2(TABLE_DEPTH);

  logic [SB_W-1:0]        curBank;
  logic [SB_W-1:0]        prevBank;
  logic [IDX_W-1:0]       prevIdx;
  logic                   prevValid;
  logic [TABLE_DEPTH-1:0] tblValid;
  logic [SB_W-1:0]        tblPred [TABLE_DEPTH];

  logic [IDX_W-1:0] lookIdx;
  logic [SB_W-1:0]  lookPred;
  logic             lookValid;

  // index: set folded to table width, XOR sub-bank
  assign lookIdx   = IDX_W'(fetchSet) ^ IDX_W'(fetchSubBank);
  assign lookPred  = tblPred[lookIdx];
  assign lookValid = tblValid[lookIdx];

  assign bankMiss = (fetchSubBank != curBank);
  assign crossing = prevValid && (fetchSubBank != prevBank);
  assign predHit  = lookValid && (lookPred != fetchSubBank);

  // precharged sub-bank register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBank <= '0;
    end else if (strobes.wakeSwitch) begin
      curBank <= fetchSubBank;
    end else if (strobes.predict) begin
      curBank <= lookPred;
    end
  end

  // history of the last accepted fetch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevBank  <= '0;
      prevIdx   <= '0;
    end else if (strobes.accept) begin
      prevValid <= 1'b1;
      prevBank  <= fetchSubBank;
      prevIdx   <= lookIdx;
    end
  end

  // prediction table: valid bits reset, payload does not
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tblValid <= '0;
    end else if (strobes.train) begin
      tblValid[prevIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.train) begin
      tblPred[prevIdx] <= fetchSubBank;
    end
  end

  // one-hot decode of the precharged sub-bank
  for (genvar g = 0; g < NUM_SUBBANKS; g++) begin : g_pchDecode
    assign prechargeEn[g] = (curBank == SB_W'(g));
  end

endmodule

// File: rtl/sbPrechargeCtrl.sv
module sbPrechargeCtrl
  import sbPrechargePkg::*;
#(
  parameter int WAKE_CYCLES = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      fetchValid,
  input  logic      bankMiss,
  input  logic      crossing,
  input  logic      predHit,
  output pcStrobe_t strobes,
  output logic      stall
);

  localparam int CNT_W = $clog2(WAKE_CYCLES + 1);

  ctlState_t        state;
  logic [CNT_W-1:0] wakeLeft;
  logic             startWake;

  assign startWake = fetchValid && (state == CTL_IDLE) && bankMiss;
  assign stall     = (state == CTL_WAKE) || (fetchValid && bankMiss);

  always_comb begin
    strobes            = '0;
    strobes.accept     = fetchValid && !stall;
    strobes.wakeSwitch = startWake;
    strobes.train      = fetchValid && !stall && crossing;
    strobes.predict    = fetchValid && !stall && predHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= CTL_IDLE;
      wakeLeft <= '0;
    end else begin
      case (state)
        CTL_IDLE: begin
          if (startWake && (WAKE_CYCLES > 1)) begin
            state    <= CTL_WAKE;
            wakeLeft <= CNT_W'(WAKE_CYCLES - 1);
          end
        end
        CTL_WAKE: begin
          if (wakeLeft <= CNT_W'(1)) begin
            state    <= CTL_IDLE;
            wakeLeft <= '0;
          end else begin
            wakeLeft <= wakeLeft - CNT_W'(1);
          end
        end
        default: state <= CTL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sbPrechargeCtl.sv
module sbPrechargeCtl
  import sbPrechargePkg::*;
#(
  parameter int NUM_SUBBANKS = 4,
  parameter int SET_BITS     = 9,
  parameter int TABLE_DEPTH  = 64,
  parameter int WAKE_CYCLES  = 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            fetchValid,
  input  logic [SET_BITS-1:0]             fetchSet,
  input  logic [$clog2(NUM_SUBBANKS)-1:0] fetchSubBank,
  output logic [NUM_SUBBANKS-1:0]         prechargeEn,
  output logic                            stall
);

  pcStrobe_t strobes;
  logic      bankMiss;
  logic      crossing;
  logic      predHit;

  sbPrechargeCtrl #(
    .WAKE_CYCLES(WAKE_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fetchValid(fetchValid),
    .bankMiss  (bankMiss),
    .crossing  (crossing),
    .predHit   (predHit),
    .strobes   (strobes),
    .stall     (stall)
  );

  sbPrechargeDp #(
    .NUM_SUBBANKS(NUM_SUBBANKS),
    .SET_BITS    (SET_BITS),
    .TABLE_DEPTH (TABLE_DEPTH)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .fetchSet    (fetchSet),
    .fetchSubBank(fetchSubBank),
    .strobes     (strobes),
    .bankMiss    (bankMiss),
    .crossing    (crossing),
    .predHit     (predHit),
    .prechargeEn (prechargeEn)
  );

endmodule

// File: rtl/sbPrechargeCtl_checker.sv
module sbPrechargeCtl_checker #(
  parameter int NUM_SUBBANKS = 4,
  parameter int WAKE_CYCLES  = 1
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            fetchValid,
  input logic [$clog2(NUM_SUBBANKS)-1:0] fetchSubBank,
  input logic [NUM_SUBBANKS-1:0]         prechargeEn,
  input logic                            stall
);

  logic [15:0]                     stallRun;
  logic [$clog2(NUM_SUBBANKS)-1:0] lastBank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallRun <= '0;
      lastBank <= '0;
    end else begin
      stallRun <= stall ? stallRun + 16'd1 : 16'd0;
      lastBank <= fetchSubBank;
    end
  end

  assert_one_hot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(prechargeEn) == 1);

  assert_reset_bank0_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (prechargeEn == NUM_SUBBANKS'(1)) && !stall);

  assert_accept_precharged_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !stall) |-> prechargeEn[fetchSubBank]);

  assert_wake_switch_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && stall && !prechargeEn[fetchSubBank]) |=> prechargeEn[lastBank]);

  assert_stall_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (stallRun < 16'(WAKE_CYCLES)));

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(fetchValid) && !$past(stall)) |-> $stable(prechargeEn));

endmodule

bind sbPrechargeCtl sbPrechargeCtl_checker #(
  .NUM_SUBBANKS(NUM_SUBBANKS),
  .WAKE_CYCLES (WAKE_CYCLES)
) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .fetchValid  (fetchValid),
  .fetchSubBank(fetchSubBank),
  .prechargeEn (prechargeEn),
  .stall       (stall)
);

// File: tb/sbPrechargeCtl_bench.sv
`timescale 1ns/1ps
module sbPrechargeCtl_bench;

  localparam int NSB   = 4;
  localparam int SETB  = 9;
  localparam int TDEP  = 64;
  localparam int WAKE  = 2;
  localparam int SBW   = $clog2(NSB);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            fetchValid = 1'b0;
  logic [SETB-1:0] fetchSet = '0;
  logic [SBW-1:0]  fetchSubBank = '0;
  logic [NSB-1:0]  prechargeEn;
  logic            stall;

  always #5 clk = ~clk;

  sbPrechargeCtl #(
    .NUM_SUBBANKS(NSB),
    .SET_BITS    (SETB),
    .TABLE_DEPTH (TDEP),
    .WAKE_CYCLES (WAKE)
  ) u_sbPrechargeCtl (
    .clk         (clk),
    .rstN        (rstN),
    .fetchValid  (fetchValid),
    .fetchSet    (fetchSet),
    .fetchSubBank(fetchSubBank),
    .prechargeEn (prechargeEn),
    .stall       (stall)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    expStall;
    int    expPch;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  // reference model
  int mCur = 0;
  bit mValid[TDEP];
  int mPred[TDEP];
  int mPrevIdx = 0;
  int mPrevBank = 0;
  bit mPrevOk = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic doFetch(int s, int b, string tag);
    expItem_t it;
    int idx;
    it.expStall = (b != mCur) ? WAKE : 0;
    mCur = b;
    idx = (s ^ b) % TDEP;
    // lookup sees table before this cycle's training write (R9)
    if (mValid[idx] && mPred[idx] != b) mCur = mPred[idx];
    if (mPrevOk && b != mPrevBank) begin
      mValid[mPrevIdx] = 1'b1;
      mPred[mPrevIdx]  = b;
    end
    mPrevIdx = idx; mPrevBank = b; mPrevOk = 1'b1;
    it.expPch = 1 << mCur;
    it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    fetchValid   = 1'b1;
    fetchSet     = SETB'(s);
    fetchSubBank = SBW'(b);
    #1;
    while (stall) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    fetchValid = 1'b0;
  endtask

  task automatic idleCheck(int n, string tag);
    fetchValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #3;
      chk(stall == 1'b0, {tag, " stall"}, int'(stall), 0);
      chk(int'(prechargeEn) == (1 << mCur), {tag, " precharge"}, int'(prechargeEn), 1 << mCur);
    end
  endtask

  // monitor: pops expected items as fetches are accepted
  int       stallRun = 0;
  bit       pend = 0;
  expItem_t cur;
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      chk($countones(prechargeEn) == 1, "R1 one-hot", int'(prechargeEn), 1);
      if (pend) begin
        chk(int'(prechargeEn) == cur.expPch, {cur.tag, " precharge after accept"},
            int'(prechargeEn), cur.expPch);
        pend = 0;
      end
      if (fetchValid) begin
        if (stall) stallRun++;
        else begin
          if (expQ.size() == 0) begin
            chk(1'b0, "R3 unexpected accept", 1, 0);
          end else begin
            cur = expQ.pop_front();
            chk(stallRun == cur.expStall, {cur.tag, " stall cycles"}, stallRun, cur.expStall);
            pend = 1;
          end
          stallRun = 0;
        end
      end
    end
  end

  task automatic finishRun();
    chk(expQ.size() == 0, "R4 pending fetches", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4 watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < TDEP; i++) begin mValid[i] = 0; mPred[i] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #3;
    chk(int'(prechargeEn) == 1, "R2 reset precharge", int'(prechargeEn), 1);
    chk(stall == 1'b0, "R2 reset stall", int'(stall), 0);

    doFetch(5, 0, "R3 hit");
    doFetch(6, 0, "R3 hit");
    doFetch(6, 2, "R4 wake");
    idleCheck(3, "R10 idle");
    doFetch(6, 0, "R6 train");
    doFetch(6, 2, "R7 predicted");
    doFetch(6, 0, "R7 predicted");
    doFetch(6, 2, "R7 predicted");
    idleCheck(2, "R10 idle");

    doFetch(3, 0, "R8 setup");
    doFetch(40, 1, "R8 setup");
    doFetch(2, 1, "R8 same bank");
    doFetch(2, 1, "R5 alias");

    doFetch(69, 0, "R5 truncate");
    doFetch(100, 3, "R5 truncate");
    doFetch(5, 0, "R5 truncate");

    doFetch(20, 0, "R9 setup");
    doFetch(7, 3, "R9 setup");
    doFetch(20, 0, "R9 setup");
    doFetch(21, 1, "R9 collide");
    doFetch(20, 0, "R9 after");

    for (int k = 0; k < 24; k++) begin
      doFetch((k * 13) % 512, (k / 3) % NSB, "R6 sweep");
    end
    for (int k = 0; k < 24; k++) begin
      doFetch((k * 13) % 512, (k / 3) % NSB, "R7 replay");
    end
    idleCheck(2, "R10 idle");

    @(negedge clk);
    @(negedge clk);
    finishRun();
  end

endmodule